// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

The block holds two timer/counter channels beside a small processor core. Each channel keeps a pair of byte registers that software can load. The pair advances on one of two sources: a machine-cycle strobe (one pulse per twelve oscillator clocks in the intended system) or falling edges on an external count pin. A channel runs while its run bit is set. It can also be made to wait for an external interrupt pin to be high, so that the pin can measure a pulse width. When a count wraps past its all-ones value, the channel sets an overflow flag for the interrupt controller.

One 8-bit mode register sets up both channels, one nibble each. Four counting shapes are available: a 13-bit count with a 5-bit prescale field, a plain 16-bit count, an 8-bit count that reloads from the high byte, and a split shape in which channel 0 becomes two independent 8-bit counters. In the split shape the second of those counters borrows channel 1's run bit and overflow flag, and channel 1 holds its count. Software clears a flag by writing it, and the interrupt controller clears it with an acknowledge pulse.

Top module: `tmr_pair`

## Requirements
- R1: After reset, the mode register, both run bits, both flags and all four count bytes are zero.
- R2: A channel advances only when its run bit is 1 and either its gate bit is 0 or its gate pin is high. The gate pin passes through two synchroniser flops, so a level first sampled at rising edge k governs edge k+2. The run bits are loaded from `run_wdata` when `run_we` is high, with bit 0 for channel 0.
- R3: With the source bit at 0, a running channel advances once for each clock that has `tick` high. With the source bit at 1, it advances once for each 1-to-0 transition of its count pin. The count changes at the second rising edge after the first edge that samples the pin low.
- R4: Shape 0 counts through lo[4:0] and carries into hi when lo[4:0] is 31. Counting never changes lo[7:5]. The wrap happens when hi is 0xFF and lo[4:0] is 31.
- R5: Shape 1 counts {hi,lo} as a 16-bit value and wraps from 0xFFFF to 0.
- R6: Shape 2 counts lo alone. When lo is 0xFF and advances, lo is loaded from hi, hi is unchanged, and the flag is set.
- R7: At the same edge where a count wraps, the owning flag becomes 1.
- R8: When channel 0 uses shape 3, lo0 counts as 8 bits under channel 0's controls and sets flag 0. hi0 counts `tick` pulses whenever run bit 1 is set, ignores channel 1's gate and source bits, and sets flag 1 when it wraps.
- R9: While channel 0 uses shape 3, channel 1's bytes hold. Channel 1 set to shape 3 also holds.
- R10: A write to `flag_we` loads both flags from `flag_wdata`. Otherwise `ack[i]` clears flag i. An overflow in the same cycle overrides both and leaves the flag at 1.
- R11: A strobe in `byte_we` (bit 0 lo0, bit 1 hi0, bit 2 lo1, bit 3 hi1) loads that byte at the next edge. That channel does not count in the same cycle.
- R12: `mode_o[3:0]` configures channel 0 and `mode_o[7:4]` configures channel 1. Within each nibble, from high bit to low: gate bit, source bit, then the 2-bit shape. The register loads from `mode_wdata` when `mode_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count pins, bit i for channel i |
| gate_pin | input | 2 | External gate pins, bit i for channel i |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| run_we | input | 1 | Run bits write strobe |
| run_wdata | input | 2 | Run bits write data |
| byte_we | input | 4 | Count byte write strobes |
| byte_wdata | input | 8 | Count byte write data |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data |
| ack | input | 2 | Interrupt acknowledge per channel |
| mode_o | output | 8 | Mode register |
| run_o | output | 2 | Run bits |
| c0_lo | output | 8 | Channel 0 low byte |
| c0_hi | output | 8 | Channel 0 high byte |
| c1_lo | output | 8 | Channel 1 low byte |
| c1_hi | output | 8 | Channel 1 high byte |
| ovf_o | output | 2 | Overflow flags |

## Verification
The checker watches several properties on every cycle:
- a stopped or gated channel holds its count;
- counting in shape 0 leaves the top three low bits alone;
- shape 2 reloads lo from hi at a wrap;
- every wrap raises its flag;
- an acknowledge clears a flag;
- a byte write lands;
- channel 1 stays frozen while channel 0 is split.

Only the bench's scenarios, compared each clock against a behavioural model, can show exact carry positions and the synchroniser latency on the count and gate pins. The same holds for edge counts under the count-pin source, for the borrowed run bit in the split shape, and for the slower twelve-clock strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;

  typedef enum logic [1:0] {
    SH_13     = 2'd0,
    SH_16     = 2'd1,
    SH_RELOAD = 2'd2,
    SH_SPLIT  = 2'd3
  } shape_e;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic              wrap;
  } step_t;

  // One advance of a byte pair in the given shape (split: low half only).
  function automatic step_t step_cnt(shape_e sh, logic [BYTE_W-1:0] hi,
                                     logic [BYTE_W-1:0] lo);
    step_t r;
    r.hi   = hi;
    r.lo   = lo;
    r.wrap = 1'b0;
    case (sh)
      SH_13: begin
        if (&lo[PRE_W-1:0]) begin
          r.lo   = {lo[BYTE_W-1:PRE_W], {PRE_W{1'b0}}};
          r.hi   = hi + 1'b1;
          r.wrap = &hi;
        end else begin
          r.lo = {lo[BYTE_W-1:PRE_W], lo[PRE_W-1:0] + 1'b1};
        end
      end
      SH_16: {r.wrap, r.hi, r.lo} = {1'b0, hi, lo} + 1'b1;
      SH_RELOAD: begin
        if (&lo) begin
          r.lo   = hi;
          r.wrap = 1'b1;
        end else begin
          r.lo = lo + 1'b1;
        end
      end
      default: begin
        r.lo   = lo + 1'b1;
        r.wrap = &lo;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_pinsync.sv
module tmr_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-1:0], pin};
  end

  assign lvl  = sr[STAGES-1];
  assign fall = sr[STAGES] & ~sr[STAGES-1];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shape_e            shape,
  input  logic              adv,
  input  logic              adv_hi,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              wrap,
  output logic              wrap_hi
);
  step_t nxt;
  logic  wr, split, idle;

  assign nxt   = step_cnt(shape, hi, lo);
  assign wr    = we_lo | we_hi;
  assign split = (shape == SH_SPLIT) && SPLIT_OK;
  assign idle  = (shape == SH_SPLIT) && !SPLIT_OK;
  assign wrap  = adv && !wr && !idle && nxt.wrap;

  generate
    if (SPLIT_OK) begin : g_split
      assign wrap_hi = split && adv_hi && !wr && (&hi);
    end else begin : g_nosplit
      assign wrap_hi = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (wr) begin
      if (we_lo) lo <= wdata;
      if (we_hi) hi <= wdata;
    end else begin
      if (adv && !idle) begin
        lo <= nxt.lo;
        if (!split) hi <= nxt.hi;
      end
      if (split && adv_hi) hi <= hi + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       run_we,
  input  logic [1:0] run_wdata,
  input  logic [3:0] byte_we,
  input  logic [7:0] byte_wdata,
  input  logic       flag_we,
  input  logic [1:0] flag_wdata,
  input  logic [1:0] ack,
  output logic [7:0] mode_o,
  output logic [1:0] run_o,
  output logic [7:0] c0_lo,
  output logic [7:0] c0_hi,
  output logic [7:0] c1_lo,
  output logic [7:0] c1_hi,
  output logic [1:0] ovf_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] gate_s, cnt_fall, adv, set_ev;
  logic           wrap0, wrap1, wrap_hi0, wrap_hi1, split0;
  shape_e         sh0, sh1;

  assign sh0    = shape_e'(mode_o[1:0]);
  assign sh1    = shape_e'(mode_o[5:4]);
  assign split0 = (sh0 == SH_SPLIT);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic gate_unused, cnt_lvl_unused;
    logic gate_ok, src;
    tmr_pinsync #(.STAGES(SYNC_STAGES)) u_gsync (
      .clk(clk), .rst_n(rst_n), .pin(gate_pin[i]),
      .lvl(gate_s[i]), .fall(gate_unused));
    tmr_pinsync #(.STAGES(SYNC_STAGES)) u_csync (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin[i]),
      .lvl(cnt_lvl_unused), .fall(cnt_fall[i]));
    assign gate_ok = !mode_o[4*i+3] || gate_s[i];
    assign src     = mode_o[4*i+2] ? cnt_fall[i] : tick;
    assign adv[i]  = run_o[i] && gate_ok && src;
  end

  tmr_chan #(.SPLIT_OK(1'b1)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .shape(sh0), .adv(adv[0]),
    .adv_hi(run_o[1] && tick), .we_lo(byte_we[0]), .we_hi(byte_we[1]),
    .wdata(byte_wdata), .lo(c0_lo), .hi(c0_hi), .wrap(wrap0), .wrap_hi(wrap_hi0));

  tmr_chan #(.SPLIT_OK(1'b0)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .shape(sh1), .adv(adv[1] && !split0),
    .adv_hi(1'b0), .we_lo(byte_we[2]), .we_hi(byte_we[3]),
    .wdata(byte_wdata), .lo(c1_lo), .hi(c1_hi), .wrap(wrap1), .wrap_hi(wrap_hi1));

  assign set_ev = {wrap1 | wrap_hi0 | wrap_hi1, wrap0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= '0;
      run_o  <= '0;
    end else begin
      if (mode_we) mode_o <= mode_wdata;
      if (run_we)  run_o  <= run_wdata;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ovf_o[i] <= 1'b0;
      else if (set_ev[i])  ovf_o[i] <= 1'b1;
      else if (flag_we)    ovf_o[i] <= flag_wdata[i];
      else if (ack[i])     ovf_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode_o,
  input logic [1:0] run_o,
  input logic [3:0] byte_we,
  input logic [7:0] byte_wdata,
  input logic       flag_we,
  input logic [1:0] ack,
  input logic [7:0] c0_lo,
  input logic [7:0] c0_hi,
  input logic [7:0] c1_lo,
  input logic [7:0] c1_hi,
  input logic [1:0] ovf_o,
  input logic [1:0] set_ev,
  input logic [1:0] gate_s
);
  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o[0] && mode_o[1:0] != 2'd3 && byte_we[1:0] == 2'b00)
      |=> $stable({c0_hi, c0_lo}));

  p_gate_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[3] && !gate_s[0] && mode_o[1:0] != 2'd3 && byte_we[1:0] == 2'b00)
      |=> $stable({c0_hi, c0_lo}));

  p_top_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[1:0] == 2'd0 && mode_o[5:4] != 2'd3 && !byte_we[0]) |=> $stable(c0_lo[7:5]));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[1:0] == 2'd2 && set_ev[0])
      |=> (c0_lo == $past(c0_hi)) && $stable(c0_hi));

  p_flag0_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[0] |=> ovf_o[0]);

  p_flag1_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[1] |=> ovf_o[1]);

  p_ch1_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[1:0] == 2'd3 && byte_we[3:2] == 2'b00) |=> $stable({c1_hi, c1_lo}));

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !flag_we && !set_ev[0]) |=> !ovf_o[0]);

  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we[0] |=> (c0_lo == $past(byte_wdata)));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .run_o(run_o),
  .byte_we(byte_we), .byte_wdata(byte_wdata), .flag_we(flag_we), .ack(ack),
  .c0_lo(c0_lo), .c0_hi(c0_hi), .c1_lo(c1_lo), .c1_hi(c1_hi),
  .ovf_o(ovf_o), .set_ev(set_ev), .gate_s(gate_s));

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] cnt_pin = 2'b11, gate_pin = 2'b00;
  logic mode_we = 0, run_we = 0, flag_we = 0;
  logic [7:0] mode_wdata = 0, byte_wdata = 0;
  logic [1:0] run_wdata = 0, flag_wdata = 0, ack = 0;
  logic [3:0] byte_we = 0;
  logic [7:0] mode_o, c0_lo, c0_hi, c1_lo, c1_hi;
  logic [1:0] run_o, ovf_o;

  tmr_pair dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, tick_div = 1;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  int m_mode, m_run, m_flag[2], m_b[4];
  int ph[2][3], gh[2][2];

  function automatic int adv_pair(int sh, inout int hi, inout int lo);
    int w = 0;
    if (sh == 0) begin
      if ((lo % 32) == 31) begin
        lo = lo - 31;
        if (hi == 255) begin hi = 0; w = 1; end else hi = hi + 1;
      end else lo = lo + 1;
    end else if (sh == 1) begin
      int v = hi * 256 + lo + 1;
      if (v == 65536) begin v = 0; w = 1; end
      hi = v / 256; lo = v % 256;
    end else if (sh == 2) begin
      if (lo == 255) begin lo = hi; w = 1; end else lo = lo + 1;
    end else begin
      if (lo == 255) begin lo = 0; w = 1; end else lo = lo + 1;
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_flag[0] = 0; m_flag[1] = 0;
      for (int k = 0; k < 4; k++) m_b[k] = 0;
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 3; k++) ph[c][k] = 0;
        gh[c][0] = 0; gh[c][1] = 0;
      end
    end else begin
      int advv[2], setv[2], hi, lo;
      int split;
      split = ((m_mode & 3) == 3);
      for (int c = 0; c < 2; c++) begin
        int gok, srcv;
        gok  = (((m_mode >> (4*c+3)) & 1) == 0) || gh[c][1];
        srcv = ((m_mode >> (4*c+2)) & 1) ? (ph[c][2] && !ph[c][1]) : int'(tick);
        advv[c] = ((m_run >> c) & 1) && gok && srcv;
        setv[c] = 0;
      end
      if (byte_we[1:0] != 0) begin
        if (byte_we[0]) m_b[0] = byte_wdata;
        if (byte_we[1]) m_b[1] = byte_wdata;
      end else begin
        if (advv[0]) begin
          hi = m_b[1]; lo = m_b[0];
          setv[0] = adv_pair(m_mode & 3, hi, lo);
          m_b[0] = lo;
          if (!split) m_b[1] = hi;
        end
        if (split && ((m_run >> 1) & 1) && tick) begin
          if (m_b[1] == 255) begin m_b[1] = 0; setv[1] = 1; end
          else m_b[1] = m_b[1] + 1;
        end
      end
      if (byte_we[3:2] != 0) begin
        if (byte_we[2]) m_b[2] = byte_wdata;
        if (byte_we[3]) m_b[3] = byte_wdata;
      end else if (advv[1] && !split && ((m_mode >> 4) & 3) != 3) begin
        hi = m_b[3]; lo = m_b[2];
        if (adv_pair((m_mode >> 4) & 3, hi, lo)) setv[1] = 1;
        m_b[3] = hi; m_b[2] = lo;
      end
      for (int c = 0; c < 2; c++) begin
        if (setv[c]) m_flag[c] = 1;
        else if (flag_we) m_flag[c] = flag_wdata[c];
        else if (ack[c]) m_flag[c] = 0;
      end
      if (mode_we) m_mode = mode_wdata;
      if (run_we) m_run = run_wdata;
      for (int c = 0; c < 2; c++) begin
        ph[c][2] = ph[c][1]; ph[c][1] = ph[c][0]; ph[c][0] = cnt_pin[c];
        gh[c][1] = gh[c][0]; gh[c][0] = gate_pin[c];
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(cur_req, "mode", mode_o, m_mode);
    check(cur_req, "run", run_o, m_run);
    check(cur_req, "c0_lo", c0_lo, m_b[0]);
    check(cur_req, "c0_hi", c0_hi, m_b[1]);
    check(cur_req, "c1_lo", c1_lo, m_b[2]);
    check(cur_req, "c1_hi", c1_hi, m_b[3]);
    check(cur_req, "flags", ovf_o, m_flag[1] * 2 + m_flag[0]);
  end

  // tick generator
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % tick_div;
    tick <= (tcnt == 0);
  end

  task automatic wr_mode(int v);
    mode_we <= 1; mode_wdata <= v[7:0]; @(negedge clk); mode_we <= 0;
  endtask
  task automatic wr_run(int v);
    run_we <= 1; run_wdata <= v[1:0]; @(negedge clk); run_we <= 0;
  endtask
  task automatic wr_byte(int idx, int v);
    byte_we <= 4'(1 << idx); byte_wdata <= v[7:0]; @(negedge clk); byte_we <= 0;
  endtask
  task automatic wr_flag(int v);
    flag_we <= 1; flag_wdata <= v[1:0]; @(negedge clk); flag_we <= 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int snap;
    idle(3); rst_n <= 1; @(negedge clk);
    cur_req = "R1";
    check("R1", "reset counts", {c1_hi, c1_lo, c0_hi, c0_lo}, 0);
    check("R1", "reset flags/run/mode", {ovf_o, run_o, mode_o}, 0);

    // R12 / R5 / R7: channel 0 16-bit timer wraps and flags
    cur_req = "R5";
    wr_mode(8'h01);
    check("R12", "mode nibble load", mode_o, 8'h01);
    wr_byte(1, 8'hFF); wr_byte(0, 8'hF0);
    wr_run(1); idle(20);
    check("R7", "flag0 after 16-bit wrap", ovf_o[0], 1);
    check("R5", "16-bit count past wrap", c0_hi, 8'h00);

    // R10 flag clearing
    cur_req = "R10";
    ack <= 2'b01; @(negedge clk); ack <= 0;
    check("R10", "ack clears flag0", ovf_o[0], 0);
    wr_flag(2'b10);
    check("R10", "software flag write", ovf_o, 2'b10);
    wr_flag(0);

    // R4 13-bit shape
    cur_req = "R4";
    wr_run(0); wr_mode(8'h00);
    wr_byte(0, 8'hFE); wr_byte(1, 8'hFF);
    wr_run(1); idle(40);
    check("R4", "upper low-byte bits kept", c0_lo[7:5], 3'b111);
    check("R7", "flag0 after 13-bit wrap", ovf_o[0], 1);

    // R6 reload shape
    cur_req = "R6";
    wr_run(0); wr_flag(0); wr_mode(8'h02);
    wr_byte(1, 8'h80); wr_byte(0, 8'hFD);
    wr_run(1); idle(10);
    check("R6", "hi unchanged in reload shape", c0_hi, 8'h80);

    // R2 gate
    cur_req = "R2";
    wr_run(0); wr_mode(8'h09); gate_pin[0] <= 0; wr_byte(0, 0); wr_byte(1, 0);
    wr_run(1); idle(10);
    check("R2", "gated low holds count", {c0_hi, c0_lo}, 0);
    gate_pin[0] <= 1; idle(10);
    check("R2", "gate high lets count run", (c0_lo != 0), 1);
    gate_pin[0] <= 0;

    // R3 count-pin source
    cur_req = "R3";
    wr_run(0); wr_mode(8'h05); wr_byte(0, 0); wr_byte(1, 0); wr_run(1);
    for (int k = 0; k < 5; k++) begin
      cnt_pin[0] <= 0; idle(3); cnt_pin[0] <= 1; idle(3);
    end
    idle(3);
    check("R3", "five pin falls counted", c0_lo, 5);

    // channel 1 with slow strobe
    cur_req = "R3";
    wr_run(0); tick_div = 12; wr_mode(8'h10); wr_run(2); idle(120);
    check("R3", "slow strobe count ch1", (c1_lo >= 9 && c1_lo <= 11), 1);
    tick_div = 1;

    // R8 / R9 split shape
    cur_req = "R8";
    wr_run(0); wr_flag(0); wr_mode(8'h13);
    wr_byte(0, 8'hF8); wr_byte(1, 8'hFC); wr_byte(2, 8'h11); wr_byte(3, 8'h22);
    wr_run(3); idle(12);
    check("R8", "split halves set both flags", ovf_o, 2'b11);
    check("R9", "ch1 held while ch0 split", {c1_hi, c1_lo}, 16'h2211);
    wr_run(2); snap = c0_lo; idle(5);
    check("R8", "lo0 stops with run0 clear", c0_lo, snap);

    // R9 channel 1 in shape 3 holds
    cur_req = "R9";
    wr_run(0); wr_mode(8'h30); wr_run(2); idle(10);
    check("R9", "ch1 shape 3 holds", {c1_hi, c1_lo}, 16'h2211);

    // R11 write while running
    cur_req = "R11";
    wr_run(0); wr_mode(8'h01); wr_run(1); idle(3);
    wr_byte(0, 8'h42);
    check("R11", "write beats count", c0_lo, 8'h42);
    idle(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule